// File: doc/BRIEF.md
# Overcurrent Alarm Filter Counter

This block watches an external overcurrent alarm pin and turns it into two actions. The first is an interrupt pulse, raised once enough alarm events have been seen. The second is a throttle request that follows the alarm and is held on for a programmed time after the alarm goes away. The raw pin is synchronised through a short flop chain. It is then corrected for polarity, so that the rest of the block only ever sees "alarm active". Each inactive-to-active transition of that corrected level counts as one event.

Events add up in a counter. When the interrupt function is enabled and the counter reaches the programmed threshold, a single-cycle interrupt pulse is issued and the counter restarts from zero. A quiet window, counted in clock cycles, guards the counter. Every event reloads the window, and if the window runs out with no further event, the count is discarded. The throttle hold is counted in ticks of an external microsecond strobe rather than in raw clocks, so long hold times need only a narrow counter.

Top module: `ocAlarmFilter`

## Requirements
- R1: While reset is asserted and directly after it, eventCount is 0, irqPulse is 0 and throttleReq is 0, provided the raw pin is at its idle level.
- R2: With cfgActiveLow = 1 the alarm is active when alarmRaw is 0 and idle when it is 1. With cfgActiveLow = 0 the alarm is active when alarmRaw is 1.
- R3: One event is counted per inactive-to-active transition of the corrected alarm, however long the level is held. The new count is visible on eventCount after the third rising clock edge that samples the changed pin.
- R4: With cfgIrqEn = 1 and cfgThreshold = T ≥ 1, the T-th event since the count was last cleared produces a one-cycle irqPulse. In that same cycle eventCount shows 0, and counting then resumes from 0.
- R5: With cfgIrqEn = 1 and cfgThreshold = 0, every event produces an irqPulse and eventCount stays 0.
- R6: With cfgIrqEn = 0, irqPulse never rises, and eventCount saturates at its all-ones value.
- R7: With cfgFilter = F > 0, a count left without a further event is cleared F clock cycles after the cycle in which it was incremented. Any event inside that window restarts the window.
- R8: With cfgFilter = 0 the count is never cleared by the quiet window.
- R9: throttleReq is 1 whenever the synchronised, polarity-corrected alarm is active.
- R10: After the alarm deasserts, throttleReq stays 1 until cfgHold = H usTick pulses have been sampled. With H = 0 it drops in the same cycle as the synchronised alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| alarmRaw | input | 1 | Asynchronous overcurrent alarm pin |
| cfgActiveLow | input | 1 | 1: pin is active low; 0: active high |
| cfgIrqEn | input | 1 | Enables interrupt generation |
| cfgThreshold | input | CNT_W | Event count that raises the interrupt (0 = every event) |
| cfgFilter | input | FILT_W | Quiet window in clock cycles (0 = never clear) |
| cfgHold | input | HOLD_W | Throttle hold after deassertion, in usTick pulses |
| usTick | input | 1 | One-cycle microsecond strobe |
| irqPulse | output | 1 | One-cycle interrupt pulse |
| throttleReq | output | 1 | Throttle request |
| eventCount | output | CNT_W | Current event count |

## Verification
The bench builds the block with a 4-bit event counter, a 6-bit quiet-window counter and a 4-bit hold counter. The narrow event counter lets saturation at 15 be reached in a few events. Thresholds 0 to 5 are swept, and each sweep's pulse total and leftover count are compared with the quotient and remainder of the event number. The window widths are swept from 1 to 8 cycles, and the measured lifetime of a single count must equal the width exactly. Hold values 0 to 5 are swept with hand-placed tick strobes, which pins down the exact tick that releases the throttle.

// File: rtl/ocf_pkg.sv
package ocf_pkg;

  // Strobes from the control decisions to the datapath registers
  typedef struct packed {
    logic countInc;
    logic countClear;
    logic irqFire;
    logic filterLoad;
    logic filterStep;
    logic holdLoad;
    logic holdStep;
  } ocfStrobes_t;

endpackage

// File: rtl/ocfAlarmSync.sv
module ocfAlarmSync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic alarmRaw,
  input  logic cfgActiveLow,
  output logic alarmLvl,
  output logic eventEdge
);

  // Polarity is folded in ahead of the chain, so reset value 0 means idle
  logic [SYNC_STAGES-1:0] chain;
  logic lvlPrev;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= alarmRaw ^ cfgActiveLow;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= 1'b0;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lvlPrev <= 1'b0;
    else       lvlPrev <= chain[SYNC_STAGES-1];
  end

  assign alarmLvl  = chain[SYNC_STAGES-1];
  assign eventEdge = alarmLvl & ~lvlPrev;

  // R3: an edge is a single-cycle strobe
  assert_single_edge_R3: assert property (@(posedge clk) disable iff (!rstN)
    eventEdge |=> !eventEdge);

endmodule

// File: rtl/ocfCtrl.sv
module ocfCtrl
  import ocf_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             eventEdge,
  input  logic             alarmLvl,
  input  logic             usTick,
  input  logic             cfgIrqEn,
  input  logic [CNT_W-1:0] cfgThreshold,
  input  logic [CNT_W-1:0] count,
  input  logic             filterLast,
  input  logic             filterBusy,
  input  logic             holdBusy,
  output ocfStrobes_t      strb
);

  localparam int WIDE_W = CNT_W + 1;

  logic [WIDE_W-1:0] nextCount;
  logic              reachThresh;
  logic              countFull;

  assign nextCount   = {1'b0, count} + WIDE_W'(1);
  assign reachThresh = nextCount >= {1'b0, cfgThreshold};
  assign countFull   = &count;

  always_comb begin
    strb            = '0;
    strb.irqFire    = eventEdge & cfgIrqEn & reachThresh;
    strb.countClear = strb.irqFire | (~eventEdge & filterLast);
    strb.countInc   = eventEdge & ~strb.irqFire & ~countFull;
    strb.filterLoad = eventEdge;
    strb.filterStep = ~eventEdge & filterBusy;
    strb.holdLoad   = alarmLvl;
    strb.holdStep   = ~alarmLvl & usTick & holdBusy;
  end

  // R6: a saturated count is never incremented
  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.countInc |-> count != '1);

endmodule

// File: rtl/ocfDatapath.sv
module ocfDatapath
  import ocf_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int FILT_W = 24,
  parameter int HOLD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ocfStrobes_t       strb,
  input  logic              alarmLvl,
  input  logic [FILT_W-1:0] cfgFilter,
  input  logic [HOLD_W-1:0] cfgHold,
  output logic [CNT_W-1:0]  count,
  output logic              filterLast,
  output logic              filterBusy,
  output logic              holdBusy,
  output logic              irqPulse,
  output logic              throttleReq
);

  logic [FILT_W-1:0] filterCnt;
  logic [HOLD_W-1:0] holdCnt;
  logic              irqQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                count <= '0;
    else if (strb.countClear) count <= '0;
    else if (strb.countInc)   count <= count + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                filterCnt <= '0;
    else if (strb.filterLoad) filterCnt <= cfgFilter;
    else if (strb.filterStep) filterCnt <= filterCnt - FILT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              holdCnt <= '0;
    else if (strb.holdLoad) holdCnt <= cfgHold;
    else if (strb.holdStep) holdCnt <= holdCnt - HOLD_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= strb.irqFire;
  end

  assign filterLast  = filterCnt == FILT_W'(1);
  assign filterBusy  = filterCnt != '0;
  assign holdBusy    = holdCnt != '0;
  assign irqPulse    = irqQ;
  assign throttleReq = alarmLvl | holdBusy;

  // R3: the count only steps by one, holds, or returns to zero
  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (count == $past(count)) || (count == $past(count) + CNT_W'(1)) || (count == '0));

  // R8: an idle window stays idle until the next event
  assert_filter_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (filterCnt == '0 && !strb.filterLoad) |=> filterCnt == '0);

  // R10: the hold counter only moves down on a tick once the alarm is gone
  assert_hold_tick_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!alarmLvl && !strb.holdStep) |=> $stable(holdCnt));

endmodule

// File: rtl/ocAlarmFilter.sv
module ocAlarmFilter
  import ocf_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int FILT_W      = 24,
  parameter int HOLD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              alarmRaw,
  input  logic              cfgActiveLow,
  input  logic              cfgIrqEn,
  input  logic [CNT_W-1:0]  cfgThreshold,
  input  logic [FILT_W-1:0] cfgFilter,
  input  logic [HOLD_W-1:0] cfgHold,
  input  logic              usTick,
  output logic              irqPulse,
  output logic              throttleReq,
  output logic [CNT_W-1:0]  eventCount
);

  logic        alarmLvl;
  logic        eventEdge;
  logic        filterLast;
  logic        filterBusy;
  logic        holdBusy;
  ocfStrobes_t strb;

  ocfAlarmSync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk          (clk),
    .rstN         (rstN),
    .alarmRaw     (alarmRaw),
    .cfgActiveLow (cfgActiveLow),
    .alarmLvl     (alarmLvl),
    .eventEdge    (eventEdge)
  );

  ocfCtrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .eventEdge    (eventEdge),
    .alarmLvl     (alarmLvl),
    .usTick       (usTick),
    .cfgIrqEn     (cfgIrqEn),
    .cfgThreshold (cfgThreshold),
    .count        (eventCount),
    .filterLast   (filterLast),
    .filterBusy   (filterBusy),
    .holdBusy     (holdBusy),
    .strb         (strb)
  );

  ocfDatapath #(.CNT_W(CNT_W), .FILT_W(FILT_W), .HOLD_W(HOLD_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .alarmLvl    (alarmLvl),
    .cfgFilter   (cfgFilter),
    .cfgHold     (cfgHold),
    .count       (eventCount),
    .filterLast  (filterLast),
    .filterBusy  (filterBusy),
    .holdBusy    (holdBusy),
    .irqPulse    (irqPulse),
    .throttleReq (throttleReq)
  );

  // R6: no interrupt unless enabled in the deciding cycle
  assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(cfgIrqEn));

  // R4: the pulse coincides with a zero count
  assert_irq_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> eventCount == '0);

  // R5: pulses never come back to back
  assert_irq_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);

endmodule

// File: tb/test_ocAlarmFilter.sv
module test_ocAlarmFilter;

  localparam int CNT_W  = 4;
  localparam int FILT_W = 6;
  localparam int HOLD_W = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              alarmRaw = 1'b0;
  logic              cfgActiveLow = 1'b0;
  logic              cfgIrqEn = 1'b0;
  logic [CNT_W-1:0]  cfgThreshold = '0;
  logic [FILT_W-1:0] cfgFilter = '0;
  logic [HOLD_W-1:0] cfgHold = '0;
  logic              usTick = 1'b0;
  logic              irqPulse;
  logic              throttleReq;
  logic [CNT_W-1:0]  eventCount;

  int checks = 0;
  int failures = 0;
  int pulseSeen = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ocAlarmFilter #(.CNT_W(CNT_W), .FILT_W(FILT_W), .HOLD_W(HOLD_W)) i_ocAlarmFilter (
    .clk(clk), .rstN(rstN), .alarmRaw(alarmRaw), .cfgActiveLow(cfgActiveLow),
    .cfgIrqEn(cfgIrqEn), .cfgThreshold(cfgThreshold), .cfgFilter(cfgFilter),
    .cfgHold(cfgHold), .usTick(usTick), .irqPulse(irqPulse),
    .throttleReq(throttleReq), .eventCount(eventCount)
  );

  always @(negedge clk) if (rstN && irqPulse) pulseSeen++;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitNeg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    waitNeg(2);
    rstN = 1'b1;
    waitNeg(1);
  endtask

  // one full alarm event: active 3 cycles, idle 3 cycles
  task automatic pulseAlarm();
    alarmRaw = ~cfgActiveLow;
    waitNeg(3);
    alarmRaw = cfgActiveLow;
    waitNeg(3);
  endtask

  initial begin
    waitNeg(3);
    check(eventCount == 0 && irqPulse == 0 && throttleReq == 0, "R1 reset", eventCount, 0);
    rstN = 1'b1;
    waitNeg(2);
    check(eventCount == 0 && throttleReq == 0, "R1 after release", eventCount, 0);

    // R3: latency and single count per held level
    cfgIrqEn = 1'b0; cfgThreshold = 4'd3;
    alarmRaw = 1'b1;
    waitNeg(2);
    check(eventCount == 0, "R3 not before third edge", eventCount, 0);
    waitNeg(1);
    check(eventCount == 1, "R3 count on third edge", eventCount, 1);
    waitNeg(6);
    check(eventCount == 1, "R3 held level counts once", eventCount, 1);
    alarmRaw = 1'b0;
    waitNeg(3);

    // R2: active-low polarity
    cfgActiveLow = 1'b1; alarmRaw = 1'b1;
    doReset();
    waitNeg(3);
    check(eventCount == 0 && throttleReq == 0, "R2 high is idle when active low", throttleReq, 0);
    alarmRaw = 1'b0;
    waitNeg(3);
    check(throttleReq == 1, "R2 low is active", throttleReq, 1);
    alarmRaw = 1'b1;
    waitNeg(3);
    check(eventCount == 1, "R2 low pulse counted", eventCount, 1);
    cfgActiveLow = 1'b0; alarmRaw = 1'b0;
    waitNeg(3);

    // R4 / R5: threshold sweep
    for (int t = 0; t <= 5; t++) begin
      int base;
      int expP;
      int expC;
      cfgIrqEn = 1'b1; cfgThreshold = CNT_W'(t); cfgFilter = '0;
      doReset();
      base = pulseSeen;
      for (int e = 0; e < 7; e++) pulseAlarm();
      expP = (t <= 1) ? 7 : 7 / t;
      expC = (t <= 1) ? 0 : 7 % t;
      if (t == 0) begin
        check(pulseSeen - base == expP, "R5 pulses at threshold 0", pulseSeen - base, expP);
        check(eventCount == expC, "R5 count stays 0", eventCount, expC);
      end else begin
        check(pulseSeen - base == expP, "R4 pulse total", pulseSeen - base, expP);
        check(eventCount == expC, "R4 leftover count", eventCount, expC);
      end
    end

    // R6: disabled interrupt, saturation
    begin
      int base;
      cfgIrqEn = 1'b0; cfgThreshold = 4'd2;
      doReset();
      base = pulseSeen;
      for (int e = 0; e < 17; e++) pulseAlarm();
      check(pulseSeen == base, "R6 no pulse when disabled", pulseSeen - base, 0);
      check(eventCount == 15, "R6 saturates", eventCount, 15);
    end

    // R7: window width sweep
    for (int f = 1; f <= 8; f++) begin
      int run;
      int guard;
      cfgIrqEn = 1'b0; cfgFilter = FILT_W'(f);
      doReset();
      alarmRaw = 1'b1;
      guard = 0;
      while (eventCount != 1 && guard < 20) begin waitNeg(1); guard++; end
      run = 0;
      while (eventCount == 1 && run < 40) begin run++; waitNeg(1); end
      check(run == f && eventCount == 0, "R7 count lifetime", run, f);
      alarmRaw = 1'b0;
      waitNeg(3);
    end

    // R7: events inside the window restart it
    cfgFilter = 6'd8;
    doReset();
    for (int e = 0; e < 3; e++) pulseAlarm();
    check(eventCount == 3, "R7 reload keeps count", eventCount, 3);
    waitNeg(10);
    check(eventCount == 0, "R7 cleared after quiet", eventCount, 0);

    // R8: zero window never clears
    cfgFilter = '0;
    doReset();
    pulseAlarm();
    waitNeg(100);
    check(eventCount == 1, "R8 no clear with zero window", eventCount, 1);

    // R9 / R10: hold sweep with hand-placed ticks
    for (int h = 0; h <= 5; h++) begin
      cfgHold = HOLD_W'(h); usTick = 1'b0;
      doReset();
      alarmRaw = 1'b1;
      waitNeg(2);
      usTick = 1'b1; waitNeg(1); usTick = 1'b0;
      waitNeg(1);
      check(throttleReq == 1, "R9 throttle while active", throttleReq, 1);
      alarmRaw = 1'b0;
      waitNeg(3);
      check(throttleReq == (h > 0), "R10 after deassert", throttleReq, h > 0);
      for (int k = 1; k <= h + 1; k++) begin
        usTick = 1'b1;
        waitNeg(1);
        usTick = 1'b0;
        check(throttleReq == (k < h), "R10 after tick", throttleReq, k < h);
      end
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule